// File: doc/BRIEF.md
# Link Power Status Interface Controller

This block supervises the power-status line that a link-layer controller drives toward the physical layer. It decides how far the PHY-to-link interface is shut down. If the line stays low for a short while, the interface goes into a low-power reset state. In that state the control and data outputs are forced to zero and link requests are masked, but the system clock keeps running. If the line stays low for a long while, the interface goes into a disabled state and the system clock enable is dropped as well. When the line is seen high again, the block issues a single interface-initialize pulse and returns the interface to normal operation.

Only the power-status line sets the interface state. The block has no link-control register input. A separate device low-power flag is raised while the interface is disabled and the port is inactive. The flag falls when the power-status line rises, when a port event occurs, or when the port becomes active. All timing is counted in system-clock cycles. The two thresholds are parameters: 128 and 1278 cycles by default, which at 49.152 MHz are about 2.6 µs and 26 µs.

Top module: `lps_iface_ctrl`

## Requirements
- R1: A low period of the synchronized power-status line shorter than RST_CYC cycles leaves every output unchanged. Any single high sample clears the low-time count, so two short low periods never add up.
- R2: After RST_CYC or more consecutive low cycles, the interface is in low-power reset: ctl_d_zero_o=1, lreq_mask_o=1, sysclk_en_o=1.
- R3: After DIS_CYC or more consecutive low cycles, the interface is disabled: sysclk_en_o=0, ctl_d_zero_o=1, lreq_mask_o=1.
- R4: While rst is high, and right after it is released, the interface is in the disabled state with the outputs of R3 and iface_init_o=0.
- R5: From the reset or disabled state, a high power-status line produces exactly one cycle of iface_init_o=1, with sysclk_en_o=1 and the outputs still forced. The interface then returns to normal: ctl_d_zero_o=0, lreq_mask_o=0, sysclk_en_o=1, iface_init_o=0.
- R6: low_power_o rises one cycle after the interface is disabled while port_inactive_i=1 and the line is low. It stays 0 while the interface is not disabled.
- R7: A port_event_i pulse clears low_power_o. The flag stays clear for the rest of that disabled period, until the interface leaves the disabled state and enters it again.
- R8: When the line rises while low_power_o=1, sysclk_en_o is 1 and low_power_o is 0 at the third clock edge after the line was sampled high.
- R9: Deasserting port_inactive_i clears low_power_o at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| lps_i | input | 1 | Power-status line from the link layer (asynchronous) |
| port_inactive_i | input | 1 | Port is disconnected, disabled or suspended |
| port_event_i | input | 1 | Port event that needs the device awake |
| sysclk_en_o | output | 1 | Enable for the system clock sent to the link |
| ctl_d_zero_o | output | 1 | Force control and data outputs to zero |
| lreq_mask_o | output | 1 | Ignore link request input |
| iface_init_o | output | 1 | One-cycle interface initialize pulse |
| low_power_o | output | 1 | Device low-power mode flag |

## Verification
The bench builds the block with RST_CYC=8 and DIS_CYC=24. With these values both shutdown depths, and the gap between them, are reached within a few dozen cycles, so random low periods below, between and above the thresholds can be mixed freely in one short run. The short thresholds also let directed cases land close to each boundary. These cases include low periods split by a single high cycle and wake-ups from the low-power flag.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    IF_NORMAL   = 2'd0,
    IF_LPRESET  = 2'd1,
    IF_DISABLED = 2'd2,
    IF_INIT     = 2'd3
  } if_state_t;
endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lps_low_timer.sv
module lps_low_timer #(
  parameter int RST_CYC = 128,
  parameter int DIS_CYC = 1278
) (
  input  logic clk,
  input  logic rst,
  input  logic lps_s_i,
  output logic past_rst_o,
  output logic past_dis_o
);
  localparam int CW = $clog2(DIS_CYC + 1);
  localparam logic [CW-1:0] RST_LIM = CW'(RST_CYC);
  localparam logic [CW-1:0] DIS_LIM = CW'(DIS_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || lps_s_i)        low_cnt <= '0;
    else if (low_cnt != DIS_LIM) low_cnt <= low_cnt + 1'b1;
  end

  assign past_rst_o = (low_cnt >= RST_LIM);
  assign past_dis_o = (low_cnt >= DIS_LIM);

  // R1: one high sample always restarts the low-time count
  p_count_clears_r1: assert property (@(posedge clk) disable iff (rst)
    lps_s_i |=> (low_cnt == '0));
  // R1: the count never passes its saturation value
  p_count_bounded_r1: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= DIS_LIM);
endmodule

// File: rtl/lps_iface_fsm.sv
module lps_iface_fsm
  import lps_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lps_s_i,
  input  logic      past_rst_i,
  input  logic      past_dis_i,
  output if_state_t state_o,
  output logic      sysclk_en_o,
  output logic      ctl_d_zero_o,
  output logic      lreq_mask_o,
  output logic      iface_init_o
);
  if_state_t state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      IF_NORMAL:   if (past_rst_i) nxt = IF_LPRESET;
      IF_LPRESET:  if (lps_s_i) nxt = IF_INIT;
                   else if (past_dis_i) nxt = IF_DISABLED;
      IF_DISABLED: if (lps_s_i) nxt = IF_INIT;
      IF_INIT:     nxt = IF_NORMAL;
      default:     nxt = IF_DISABLED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= IF_DISABLED;
      sysclk_en_o  <= 1'b0;
      ctl_d_zero_o <= 1'b1;
      lreq_mask_o  <= 1'b1;
      iface_init_o <= 1'b0;
    end else begin
      state        <= nxt;
      sysclk_en_o  <= (nxt != IF_DISABLED);
      ctl_d_zero_o <= (nxt != IF_NORMAL);
      lreq_mask_o  <= (nxt != IF_NORMAL);
      iface_init_o <= (nxt == IF_INIT);
    end
  end

  assign state_o = state;

  // R2: the reset state keeps the clock running with the outputs forced
  p_lpreset_outputs_r2: assert property (@(posedge clk) disable iff (rst)
    (state == IF_LPRESET) |-> (sysclk_en_o && ctl_d_zero_o && lreq_mask_o));
  // R5: initialization lasts one cycle and leads to normal operation
  p_init_then_normal_r5: assert property (@(posedge clk) disable iff (rst)
    (state == IF_INIT) |=> (state == IF_NORMAL));
  // R3: the normal state only leaves once the short threshold has been passed
  p_leave_normal_r3: assert property (@(posedge clk) disable iff (rst)
    ((state == IF_NORMAL) && (nxt != IF_NORMAL)) |-> past_rst_i);
endmodule

// File: rtl/lps_sleep_ctrl.sv
module lps_sleep_ctrl
  import lps_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  if_state_t state_i,
  input  logic      lps_s_i,
  input  logic      port_inactive_i,
  input  logic      port_event_i,
  input  logic      sysclk_en_i,
  output logic      low_power_o
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed       <= 1'b1;
      low_power_o <= 1'b0;
    end else begin
      if (state_i != IF_DISABLED) armed <= 1'b1;
      else if (port_event_i)      armed <= 1'b0;
      low_power_o <= (state_i == IF_DISABLED) && armed && !port_event_i
                     && port_inactive_i && !lps_s_i;
    end
  end

  // R6: low-power mode never coexists with a running system clock
  p_sleep_no_clock_r6: assert property (@(posedge clk) disable iff (rst)
    low_power_o |-> !sysclk_en_i);
  // R7: a port event always ends low-power mode
  p_event_wakes_r7: assert property (@(posedge clk) disable iff (rst)
    port_event_i |=> !low_power_o);
endmodule

// File: rtl/lps_iface_ctrl.sv
module lps_iface_ctrl
  import lps_pkg::*;
#(
  parameter int RST_CYC     = 128,
  parameter int DIS_CYC     = 1278,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lps_i,
  input  logic port_inactive_i,
  input  logic port_event_i,
  output logic sysclk_en_o,
  output logic ctl_d_zero_o,
  output logic lreq_mask_o,
  output logic iface_init_o,
  output logic low_power_o
);
  logic      lps_s, past_rst, past_dis;
  if_state_t state;

  lps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(lps_i), .q_o(lps_s)
  );

  lps_low_timer #(.RST_CYC(RST_CYC), .DIS_CYC(DIS_CYC)) u_timer (
    .clk(clk), .rst(rst), .lps_s_i(lps_s),
    .past_rst_o(past_rst), .past_dis_o(past_dis)
  );

  lps_iface_fsm u_fsm (
    .clk(clk), .rst(rst), .lps_s_i(lps_s),
    .past_rst_i(past_rst), .past_dis_i(past_dis),
    .state_o(state), .sysclk_en_o(sysclk_en_o),
    .ctl_d_zero_o(ctl_d_zero_o), .lreq_mask_o(lreq_mask_o),
    .iface_init_o(iface_init_o)
  );

  lps_sleep_ctrl u_sleep (
    .clk(clk), .rst(rst), .state_i(state), .lps_s_i(lps_s),
    .port_inactive_i(port_inactive_i), .port_event_i(port_event_i),
    .sysclk_en_i(sysclk_en_o), .low_power_o(low_power_o)
  );

  // R3: a stopped system clock always comes with forced outputs
  p_stopped_clock_forced_r3: assert property (@(posedge clk) disable iff (rst)
    !sysclk_en_o |-> (ctl_d_zero_o && lreq_mask_o));
endmodule

// File: tb/lps_iface_ctrl_test.sv
module lps_iface_ctrl_test;
  localparam int RST_CYC = 8;
  localparam int DIS_CYC = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lps = 1'b0, inact = 1'b0, evt = 1'b0;
  logic sclk, zero, mask, init, lpm;
  int total = 0, bad = 0, init_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lps_iface_ctrl #(.RST_CYC(RST_CYC), .DIS_CYC(DIS_CYC)) uut (
    .clk(clk), .rst(rst), .lps_i(lps), .port_inactive_i(inact),
    .port_event_i(evt), .sysclk_en_o(sclk), .ctl_d_zero_o(zero),
    .lreq_mask_o(mask), .iface_init_o(init), .low_power_o(lpm)
  );

  always @(negedge clk) if (init) init_seen++;

  // expected {sysclk_en, ctl_d_zero, lreq_mask} per mode: 0 normal, 1 reset, 2 disabled
  function automatic logic [2:0] exp_out(int mode);
    case (mode)
      0: return 3'b100;
      1: return 3'b111;
      default: return 3'b011;
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(logic [3:0] act, logic [3:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_mode(int mode, string tag);
    chk({1'b0, sclk, zero, mask}, {1'b0, exp_out(mode)}, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    inact = 1'b1;
    tick(3);
    chk_mode(2, "R4 disabled during reset");
    chk({3'b0, init}, 4'b0, "R4 no init in reset");
    rst = 1'b0;
    tick(1);
    chk_mode(2, "R4 disabled after reset");
    tick(1);
    chk({3'b0, lpm}, 4'b1, "R6 low power after reset");
    // R8 wake from low power
    @(negedge clk); lps = 1'b1; init_seen = 0;
    tick(2);
    chk({3'b0, sclk}, 4'b0, "R8 clock still off after two edges");
    tick(1);
    chk({2'b0, sclk, lpm}, 4'b0010, "R8 clock on, low power off");
    tick(4);
    chk_mode(0, "R5 normal after init");
    chk(4'(init_seen), 4'd1, "R5 single init pulse");
    // R1 short lows separated by one high cycle
    lps = 1'b0; tick(RST_CYC - 3);
    lps = 1'b1; tick(1);
    lps = 1'b0; tick(RST_CYC - 3);
    lps = 1'b1; tick(4);
    chk_mode(0, "R1 split lows ignored");
    // R2 exact entry region
    lps = 1'b0; tick(RST_CYC);
    chk_mode(0, "R1 still normal before threshold");
    tick(5);
    chk_mode(1, "R2 low-power reset");
    // R3 disabled, then R6 / R7 / R9
    tick(DIS_CYC);
    chk_mode(2, "R3 disabled");
    chk({3'b0, lpm}, 4'b1, "R6 low power while disabled and inactive");
    evt = 1'b1; tick(1); evt = 1'b0;
    chk({3'b0, lpm}, 4'b0, "R7 event clears low power");
    tick(5);
    chk({3'b0, lpm}, 4'b0, "R7 stays clear in same disabled period");
    lps = 1'b1; tick(6);
    lps = 1'b0; tick(DIS_CYC + 6);
    chk({3'b0, lpm}, 4'b1, "R7 re-armed on new disabled period");
    inact = 1'b0; tick(1);
    chk({3'b0, lpm}, 4'b0, "R9 port active clears low power");
    inact = 1'b1; tick(1);
    chk({3'b0, lpm}, 4'b1, "R6 low power returns");
    lps = 1'b1; tick(6);
    // random low periods
    for (int i = 0; i < 40; i++) begin
      int cat, len;
      cat = int'($urandom % 3);
      inact = 1'($urandom);
      case (cat)
        0: len = 1 + int'($urandom % (RST_CYC - 3));
        1: len = RST_CYC + 4 + int'($urandom % (DIS_CYC - RST_CYC - 7));
        default: len = DIS_CYC + 4 + int'($urandom % 16);
      endcase
      lps = 1'b0; init_seen = 0;
      tick(len);
      chk_mode(cat, $sformatf("R1 R2 R3 random low len=%0d", len));
      chk({3'b0, lpm}, {3'b0, (cat == 2) && inact}, "R6 random low power");
      lps = 1'b1; tick(6);
      chk_mode(0, "R5 random return to normal");
      chk(4'(init_seen), (cat == 0) ? 4'd0 : 4'd1, "R5 random init count");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule